// File: doc/BRIEF.md
# Supply Rail Fault Qualifier with Start-Up Blanking

This block sits behind the digital outputs of the supply-monitor comparators. It decides when a raw fault flag has turned into a real fault. It watches three kinds of flag: overvoltage, undervoltage and overcurrent. Each kind is watched on three rails: the 3.3 V rail, the 5 V rail and the 12 V rail. That gives nine independent sources. Each source is first passed through a two-flop synchroniser. It then needs its own persistence filter. A flag counts as qualified only once it has stayed high, without a break, for a set number of time-base ticks. The default is 73 ticks of a 1 us enable, which is 73 us.

When the supply sequencer switches the main rails on, it pulses a strobe. This strobe opens a start-up blanking window, 75 ms by default. While the window is open, the undervoltage and overcurrent filters are held at zero. The overvoltage filters keep running. A new strobe that arrives during an open window starts the window again from its full length. When any source becomes qualified, the block gives a single-cycle fault-set strobe to the latch that shuts the supply down. It also records the cause in a sticky vector.

Top module: `rail_fault_qualifier`

## Requirements
- R1: While `rst` is high, and on the cycle after it falls, `faultSet` is 0 and `causeVec` is all zeros.
- R2: With `tickEn` held high, a flag that stays high makes `faultSet` rise on the (FILT_TICKS+2)-th rising edge after the first edge that samples the flag high. The two synchroniser stages and the output register account for the extra edges.
- R3: If a flag falls before it has been seen high for FILT_TICKS consecutive ticks, its count restarts from zero. Two short pulses therefore never add up to a fault.
- R4: A filter advances only on cycles where `tickEn` is high. With `tickEn` low, a held flag never qualifies.
- R5: `faultSet` is high for one cycle per qualification, even while the flag stays high. A source can fire again only after its flag falls and qualifies anew.
- R6: `causeVec` sets bit r for overvoltage on rail r, bit NUM_RAILS+r for undervoltage on rail r, and bit 2*NUM_RAILS+r for overcurrent on rail r. Rail 0 is 3.3 V, rail 1 is 5 V and rail 2 is 12 V. Bits stay set until reset.
- R7: Sources that qualify in the same cycle give one `faultSet` pulse, and their bits appear in `causeVec` together.
- R8: A `blankStart` pulse holds the undervoltage and overcurrent filters at zero for BLANK_TICKS ticks. An undervoltage or overcurrent flag raised together with the pulse fires on edge BLANK_TICKS+FILT_TICKS+1 after the strobe edge, with `tickEn` held high.
- R9: Overvoltage filters ignore the blanking window.
- R10: A `blankStart` pulse while the window is open restarts the window at its full length.
- R11: `rst` also closes an open blanking window and clears all filters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | Time-base enable, one cycle per tick |
| blankStart | input | 1 | Strobe that opens the start-up blanking window |
| ovFlags | input | NUM_RAILS | Overvoltage comparator flags, one bit per rail (asynchronous) |
| uvFlags | input | NUM_RAILS | Undervoltage comparator flags, one bit per rail (asynchronous) |
| ocFlags | input | NUM_RAILS | Overcurrent comparator flags, one bit per rail (asynchronous) |
| faultSet | output | 1 | One-cycle strobe when any source newly qualifies |
| causeVec | output | 3*NUM_RAILS | Sticky record of the sources that have qualified |

## Verification
Two sources can qualify on the same edge, and the output then has to merge them into one strobe. The bench raises an overvoltage flag and an overcurrent flag on the same clock and expects one pulse carrying both cause bits. It then raises two flags one cycle apart and expects two pulses on consecutive cycles. A second collision happens when a blanking strobe lands on the same clock as a fresh undervoltage flag. Here the expected firing edge is worked out from the window length plus the filter length. An overvoltage flag under the same strobe is expected to fire on the unblanked schedule.

// File: rtl/rail_fault_pkg.sv
package rail_fault_pkg;
  // Strobes the control half hands to the filter datapath.
  typedef struct packed {
    logic tick;         // time-base advance
    logic blankActive;  // start-up window open: hold slow sources at zero
  } qualCtrl_t;

  localparam int KIND_COUNT = 3;  // overvoltage, undervoltage, overcurrent
endpackage

// File: rtl/rfq_persist_filter.sv
module rfq_persist_filter #(
  parameter int FILT_TICKS = 73
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic hold,
  input  logic level,
  output logic qualified
);
  localparam int CW = $clog2(FILT_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FILT_TICKS);

  logic [CW-1:0] runCnt;

  always_ff @(posedge clk) begin
    if (rst || !level || hold) runCnt <= '0;
    else if (tick && runCnt != LIMIT) runCnt <= runCnt + CW'(1);
  end

  assign qualified = (runCnt == LIMIT);
endmodule

// File: rtl/rfq_blank_ctrl.sv
module rfq_blank_ctrl
  import rail_fault_pkg::*;
#(
  parameter int BLANK_TICKS = 75000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tickEn,
  input  logic      blankStart,
  output qualCtrl_t ctrl
);
  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam logic [BW-1:0] WINDOW = BW'(BLANK_TICKS);

  logic [BW-1:0] blankLeft;

  always_ff @(posedge clk) begin
    if (rst) blankLeft <= '0;
    else if (blankStart) blankLeft <= WINDOW;
    else if (tickEn && blankLeft != '0) blankLeft <= blankLeft - BW'(1);
  end

  always_comb begin
    ctrl.tick        = tickEn;
    ctrl.blankActive = (blankLeft != '0);
  end
endmodule

// File: rtl/rfq_datapath.sv
module rfq_datapath
  import rail_fault_pkg::*;
#(
  parameter int NUM_RAILS   = 3,
  parameter int FILT_TICKS  = 73,
  parameter int SYNC_STAGES = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  qualCtrl_t                        ctrl,
  input  logic [KIND_COUNT*NUM_RAILS-1:0]  rawFlags,
  output logic                             faultSet,
  output logic [KIND_COUNT*NUM_RAILS-1:0]  causeVec
);
  localparam int NF = KIND_COUNT * NUM_RAILS;

  logic [SYNC_STAGES-1:0][NF-1:0] syncPipe;
  logic [NF-1:0] holdVec;
  logic [NF-1:0] qualVec;
  logic [NF-1:0] qualPrev;
  logic [NF-1:0] newQual;

  always_ff @(posedge clk) begin
    if (rst) syncPipe <= '0;
    else begin
      syncPipe[0] <= rawFlags;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_src
    if (i < NUM_RAILS) begin : g_fast
      assign holdVec[i] = 1'b0;           // overvoltage: never blanked
    end else begin : g_slow
      assign holdVec[i] = ctrl.blankActive;
    end
    rfq_persist_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
      .clk(clk), .rst(rst), .tick(ctrl.tick), .hold(holdVec[i]),
      .level(syncPipe[SYNC_STAGES-1][i]), .qualified(qualVec[i])
    );
  end

  assign newQual = qualVec & ~qualPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      qualPrev <= '0;
      faultSet <= 1'b0;
      causeVec <= '0;
    end else begin
      qualPrev <= qualVec;
      faultSet <= |newQual;
      causeVec <= causeVec | newQual;
    end
  end
endmodule

// File: rtl/rail_fault_qualifier.sv
module rail_fault_qualifier
  import rail_fault_pkg::*;
#(
  parameter int NUM_RAILS   = 3,
  parameter int FILT_TICKS  = 73,
  parameter int BLANK_TICKS = 75000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tickEn,
  input  logic                    blankStart,
  input  logic [NUM_RAILS-1:0]    ovFlags,
  input  logic [NUM_RAILS-1:0]    uvFlags,
  input  logic [NUM_RAILS-1:0]    ocFlags,
  output logic                    faultSet,
  output logic [3*NUM_RAILS-1:0]  causeVec
);
  qualCtrl_t ctrl;

  rfq_blank_ctrl #(.BLANK_TICKS(BLANK_TICKS)) u_ctrl (
    .clk(clk), .rst(rst), .tickEn(tickEn), .blankStart(blankStart), .ctrl(ctrl)
  );

  rfq_datapath #(
    .NUM_RAILS(NUM_RAILS), .FILT_TICKS(FILT_TICKS), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl),
    .rawFlags({ocFlags, uvFlags, ovFlags}),
    .faultSet(faultSet), .causeVec(causeVec)
  );
endmodule

// File: rtl/rail_fault_qualifier_chk.sv
module rail_fault_qualifier_chk #(
  parameter int NUM_RAILS   = 3,
  parameter int BLANK_TICKS = 75000
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tickEn,
  input logic                   blankStart,
  input logic                   faultSet,
  input logic [3*NUM_RAILS-1:0] causeVec
);
  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam logic [3*NUM_RAILS-1:0] SLOW_MASK = {{(2*NUM_RAILS){1'b1}}, {NUM_RAILS{1'b0}}};

  // Independent window tracker built from the ports.
  logic [BW-1:0] winLeft;
  always_ff @(posedge clk) begin
    if (rst) winLeft <= '0;
    else if (blankStart) winLeft <= BW'(BLANK_TICKS);
    else if (tickEn && winLeft != '0) winLeft <= winLeft - BW'(1);
  end

  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!faultSet && causeVec == '0));

  // R2 / R6: a strobe always carries at least one cause
  a_r6_strobe_has_cause: assert property (@(posedge clk) disable iff (rst)
    faultSet |-> (causeVec != '0));

  // R6: cause bits never clear outside reset
  a_r6_cause_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((causeVec & $past(causeVec)) == $past(causeVec)));

  // R4: a qualification needs a tick two cycles before the strobe
  a_r4_tick_before_fault: assert property (@(posedge clk) disable iff (rst)
    faultSet |-> $past(tickEn, 2));

  // R8: no undervoltage/overcurrent bit is newly set from an open window
  a_r8_blank_masks_slow: assert property (@(posedge clk) disable iff (rst)
    (faultSet && $past(winLeft, 2) != '0) |-> ((causeVec & ~$past(causeVec) & SLOW_MASK) == '0));
endmodule

bind rail_fault_qualifier rail_fault_qualifier_chk #(
  .NUM_RAILS(NUM_RAILS), .BLANK_TICKS(BLANK_TICKS)
) u_chk (
  .clk(clk), .rst(rst), .tickEn(tickEn), .blankStart(blankStart),
  .faultSet(faultSet), .causeVec(causeVec)
);

// File: tb/rail_fault_qualifier_test.sv
module rail_fault_qualifier_test;
  localparam int NR = 3;
  localparam int F  = 4;
  localparam int B  = 12;
  localparam int NF = 3 * NR;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tickEn = 1'b1;
  logic blankStart = 1'b0;
  logic [NF-1:0] flags = '0;   // {oc, uv, ov}
  logic faultSet;
  logic [NF-1:0] causeVec;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  rail_fault_qualifier #(.NUM_RAILS(NR), .FILT_TICKS(F), .BLANK_TICKS(B), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .tickEn(tickEn), .blankStart(blankStart),
    .ovFlags(flags[NR-1:0]), .uvFlags(flags[2*NR-1:NR]), .ocFlags(flags[3*NR-1:2*NR]),
    .faultSet(faultSet), .causeVec(causeVec)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; flags = '0; blankStart = 1'b0; tickEn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  // Counts posedges until faultSet is seen; -1 if not within limit.
  task automatic waitFault(input int limit, output int n);
    n = -1;
    for (int k = 1; k <= limit; k++) begin
      @(posedge clk);
      #1;
      blankStart = 1'b0;
      if (faultSet) begin n = k; break; end
    end
  endtask

  initial begin
    int n;
    // R1: reset state
    doReset();
    check(faultSet == 1'b0 && causeVec == '0, "R1 reset state", int'(causeVec), 0);

    // R2 / R5 / R6: each source alone
    for (int i = 0; i < NF; i++) begin
      doReset();
      flags[i] = 1'b1;
      waitFault(50, n);
      check(n == F + 3, "R2 latency", n, F + 3);
      check(causeVec == NF'(1) << i, "R6 cause bit position", int'(causeVec), 1 << i);
      @(posedge clk); #1;
      check(!faultSet, "R5 single strobe", int'(faultSet), 0);
      waitFault(10, n);
      check(n == -1 && causeVec == NF'(1) << i, "R6 sticky / R5 no refire", n, -1);
    end

    // R3: pulse length sweep on one source
    for (int len = 1; len <= F + 2; len++) begin
      doReset();
      flags[NR+1] = 1'b1;
      repeat (len) @(negedge clk);
      flags[NR+1] = 1'b0;
      waitFault(3 * F + 6, n);
      check((n != -1) == (len >= F), "R3 persistence threshold", int'(n != -1), int'(len >= F));
    end
    // R3: two short pulses with a gap do not add up
    doReset();
    flags[2] = 1'b1; repeat (F - 1) @(negedge clk);
    flags[2] = 1'b0; @(negedge clk);
    flags[2] = 1'b1; repeat (F - 1) @(negedge clk);
    flags[2] = 1'b0;
    waitFault(20, n);
    check(n == -1 && causeVec == '0, "R3 restart after drop", n, -1);

    // R4: no ticks, no progress
    doReset();
    tickEn = 1'b0;
    flags[2*NR] = 1'b1;
    waitFault(40, n);
    check(n == -1, "R4 held without ticks", n, -1);
    @(negedge clk);
    tickEn = 1'b1;
    waitFault(40, n);
    check(n == F + 1, "R4 counts from zero once ticks resume", n, F + 1);

    // R7: same-cycle qualification merges
    doReset();
    flags[0] = 1'b1; flags[2*NR+2] = 1'b1;
    waitFault(50, n);
    check(n == F + 3, "R7 merged latency", n, F + 3);
    check(causeVec == ((NF'(1) << 0) | (NF'(1) << (2*NR+2))), "R7 both causes", int'(causeVec),
          (1 << 0) | (1 << (2*NR+2)));
    @(posedge clk); #1;
    check(!faultSet, "R7 one strobe only", int'(faultSet), 0);
    // R7: one cycle apart gives two strobes
    doReset();
    flags[1] = 1'b1; @(negedge clk);
    flags[NR] = 1'b1;
    waitFault(50, n);
    check(n == F + 2 && causeVec == NF'(1) << 1, "R7 first of staggered", n, F + 2);
    @(posedge clk); #1;
    check(faultSet && causeVec == ((NF'(1) << 1) | (NF'(1) << NR)), "R7 second of staggered",
          int'(causeVec), (1 << 1) | (1 << NR));

    // R8: blanking delays undervoltage and overcurrent
    for (int i = NR; i < NF; i++) begin
      doReset();
      blankStart = 1'b1; flags[i] = 1'b1;
      waitFault(100, n);
      check(n == B + F + 2, "R8 blanked latency", n, B + F + 2);
    end

    // R9: overvoltage ignores blanking
    for (int i = 0; i < NR; i++) begin
      doReset();
      blankStart = 1'b1; flags[i] = 1'b1;
      waitFault(100, n);
      check(n == F + 3, "R9 overvoltage unblanked", n, F + 3);
    end

    // R10: restart of an open window
    doReset();
    blankStart = 1'b1; flags[NR+2] = 1'b1;
    waitFault(5, n);
    check(n == -1, "R10 quiet in first window", n, -1);
    @(negedge clk);
    blankStart = 1'b1;
    waitFault(100, n);
    check(n == B + F + 2, "R10 window restarted", n, B + F + 2);

    // R11: reset closes the window
    doReset();
    blankStart = 1'b1;
    @(negedge clk);
    blankStart = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!faultSet && causeVec == '0, "R11 cleared by reset", int'(causeVec), 0);
    flags[2*NR+1] = 1'b1;
    waitFault(100, n);
    check(n == F + 3, "R11 no blanking after reset", n, F + 3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule